// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns two digital supply-status flags into a clean system reset. One flag reports that the monitored supply sits above its trip threshold. The other reports that the supply is high enough for the reset output to be meaningful at all. While either flag is low, reset is driven active. Once both flags are good, reset stays active until a fixed number of timebase ticks have passed with the supply continuously good, and only then is it released. Any dip during that window throws the count away and starts it over.

A chip-select watchdog can also be switched on. If chip select sits at one level, high or low, for longer than the selected period, the watchdog forces a full recovery timeout on the reset output. Each falling edge of chip select restarts the watchdog. The timebase is a one-cycle tick input, nominally 1 kHz, so a simulation can scale time by pulsing it more often. A parameter selects whether the output is an active-low or an active-high reset.

Top module: `supply_reset_seq`

## Requirements
- R1: A low above-trip flag drives reset active after exactly two clock edges of input synchronisation, and reset stays active for as long as the flag is low.
- R2: After both supply flags are good and synchronised, reset stays active through HOLD_TICKS-1 ticks and is released on the clock edge that samples tick number HOLD_TICKS (default 200).
- R3: A low above-trip flag during the recovery window clears the tick count, so a full HOLD_TICKS ticks are needed after the supply comes back.
- R4: Reset is active while the power-on reset input is low, and it stays active for as long as the supply-valid flag is low, whatever the ticks and the above-trip flag do.
- R5: The 2-bit watchdog select picks the period: 2'b00 gives WD_TICKS_LONG (default 1400), 2'b01 gives WD_TICKS_MID (default 600), 2'b10 gives WD_TICKS_SHORT (default 200). With chip select unchanged, reset goes active on the clock edge that samples the period's last tick.
- R6: A falling edge of chip select restarts the watchdog count from zero; a rising edge does not.
- R7: A watchdog-caused reset lasts exactly HOLD_TICKS ticks, and the watchdog count is held at zero while reset is active, so a full period is needed after the release.
- R8: With ACTIVE_LOW=1 the output is 0 while reset is active; with ACTIVE_LOW=0 it is 1 while reset is active.
- R9: Watchdog select 2'b11 disables the watchdog: a static chip select never causes a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_i | input | 1 | One-cycle timebase pulse, synchronous to clk |
| above_trip_i | input | 1 | Supply above trip threshold (asynchronous) |
| supply_valid_i | input | 1 | Supply high enough for a valid reset output (asynchronous) |
| cs_n_i | input | 1 | Chip select watched by the watchdog (asynchronous) |
| wd_sel_i | input | 2 | Watchdog period select; 2'b11 disables |
| rst_o | output | 1 | System reset, polarity set by ACTIVE_LOW |

## Verification
On every cycle the assertions check that a bad supply flag clears the recovery count and holds reset, that reset is released only on a tick that ends a full count, that a watchdog expiry turns into reset on the next cycle, that the watchdog counter sits at zero after a chip-select falling edge or while reset is active, and that a disabled watchdog never fires. Exact tick counts before release and before expiry for each select code, the restart after a dip, the difference between falling and rising chip-select edges, the two-edge synchroniser latency and the two output polarities are only shown by the bench's directed scenarios.

// File: rtl/supply_rst_pkg.sv
package supply_rst_pkg;

  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  // Period in ticks for a select code; zero means the watchdog is off.
  function automatic int unsigned wd_limit(input logic [1:0] sel,
                                           input int unsigned t_long,
                                           input int unsigned t_mid,
                                           input int unsigned t_short);
    case (sel)
      WD_LONG:  return t_long;
      WD_MID:   return t_mid;
      WD_SHORT: return t_short;
      default:  return 0;
    endcase
  endfunction

  function automatic logic wd_enabled(input logic [1:0] sel);
    return sel != WD_OFF;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Bits needed to count 0 .. n-1, never less than one.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sra_sync.sv
module sra_sync #(
  parameter int unsigned            WIDTH  = 3,
  parameter int unsigned            STAGES = 2,
  parameter logic [WIDTH-1:0]       RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain[s] <= RST_VAL;
        else         chain[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain[s] <= RST_VAL;
        else         chain[s] <= chain[s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/sra_hold_timer.sv
module sra_hold_timer
  import supply_rst_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 200,
  localparam int unsigned HW = cnt_bits(HOLD_TICKS)
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          tick_i,
  input  logic          supply_ok_i,
  input  logic          wd_fire_i,
  output logic          rst_active_o,
  output logic          release_o,
  output logic [HW-1:0] hold_cnt_o
);

  localparam logic [HW-1:0] LAST = HW'(HOLD_TICKS - 1);

  logic          hold_q;
  logic [HW-1:0] cnt_q;
  logic          restart;
  logic          at_last;

  assign restart = !supply_ok_i || wd_fire_i;
  assign at_last = (cnt_q == LAST);
  assign release_o = hold_q && !restart && tick_i && at_last;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (restart) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_q && tick_i) begin
      if (at_last) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_active_o = hold_q || !supply_ok_i;
  assign hold_cnt_o   = cnt_q;

endmodule

// File: rtl/sra_cs_watchdog.sv
module sra_cs_watchdog
  import supply_rst_pkg::*;
#(
  parameter int unsigned WD_TICKS_LONG  = 1400,
  parameter int unsigned WD_TICKS_MID   = 600,
  parameter int unsigned WD_TICKS_SHORT = 200,
  localparam int unsigned WW = cnt_bits(max3(WD_TICKS_LONG, WD_TICKS_MID, WD_TICKS_SHORT))
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          tick_i,
  input  logic          cs_n_s_i,
  input  logic [1:0]    wd_sel_i,
  input  logic          rst_active_i,
  output logic          cs_fall_o,
  output logic          wd_fire_o,
  output logic [WW-1:0] wd_cnt_o
);

  logic          cs_prev_q;
  logic [WW-1:0] cnt_q;
  logic [WW-1:0] last;
  logic          enabled;
  logic          clear;
  logic          at_last;

  assign enabled = wd_enabled(wd_sel_i);
  assign last    = WW'(wd_limit(wd_sel_i, WD_TICKS_LONG, WD_TICKS_MID, WD_TICKS_SHORT) - 1);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cs_prev_q <= 1'b1;
    else         cs_prev_q <= cs_n_s_i;
  end

  assign cs_fall_o = cs_prev_q && !cs_n_s_i;
  assign clear     = rst_active_i || !enabled || cs_fall_o;
  assign at_last   = (cnt_q == last);
  assign wd_fire_o = tick_i && !clear && at_last;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end

  assign wd_cnt_o = cnt_q;

endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import supply_rst_pkg::*;
#(
  parameter bit          ACTIVE_LOW     = 1'b1,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned HOLD_TICKS     = 200,
  parameter int unsigned WD_TICKS_LONG  = 1400,
  parameter int unsigned WD_TICKS_MID   = 600,
  parameter int unsigned WD_TICKS_SHORT = 200
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       tick_i,
  input  logic       above_trip_i,
  input  logic       supply_valid_i,
  input  logic       cs_n_i,
  input  logic [1:0] wd_sel_i,
  output logic       rst_o
);

  localparam int unsigned HW = cnt_bits(HOLD_TICKS);
  localparam int unsigned WW = cnt_bits(max3(WD_TICKS_LONG, WD_TICKS_MID, WD_TICKS_SHORT));

  // Bit order of the synchronised vector: {supply_valid, above_trip, cs_n}
  logic [2:0]    raw_in;
  logic [2:0]    sync_in;
  logic          valid_s;
  logic          trip_s;
  logic          cs_n_s;
  logic          supply_ok;
  logic          rst_active;
  logic          release_evt;
  logic [HW-1:0] hold_cnt;
  logic          cs_fall;
  logic          wd_fire;
  logic [WW-1:0] wd_cnt;

  assign raw_in = {supply_valid_i, above_trip_i, cs_n_i};

  sra_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b001)
  ) u_sync (
    .clk   (clk),
    .arst_n(arst_n),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  assign {valid_s, trip_s, cs_n_s} = sync_in;
  assign supply_ok = valid_s && trip_s;

  sra_hold_timer #(
    .HOLD_TICKS(HOLD_TICKS)
  ) u_hold (
    .clk         (clk),
    .arst_n      (arst_n),
    .tick_i      (tick_i),
    .supply_ok_i (supply_ok),
    .wd_fire_i   (wd_fire),
    .rst_active_o(rst_active),
    .release_o   (release_evt),
    .hold_cnt_o  (hold_cnt)
  );

  sra_cs_watchdog #(
    .WD_TICKS_LONG (WD_TICKS_LONG),
    .WD_TICKS_MID  (WD_TICKS_MID),
    .WD_TICKS_SHORT(WD_TICKS_SHORT)
  ) u_wd (
    .clk         (clk),
    .arst_n      (arst_n),
    .tick_i      (tick_i),
    .cs_n_s_i    (cs_n_s),
    .wd_sel_i    (wd_sel_i),
    .rst_active_i(rst_active),
    .cs_fall_o   (cs_fall),
    .wd_fire_o   (wd_fire),
    .wd_cnt_o    (wd_cnt)
  );

  if (ACTIVE_LOW) begin : g_out_low
    assign rst_o = !rst_active;
  end else begin : g_out_high
    assign rst_o = rst_active;
  end

endmodule

// File: rtl/supply_reset_seq_chk.sv
module supply_reset_seq_chk #(
  parameter int unsigned HOLD_TICKS = 200,
  parameter int unsigned HW = 8,
  parameter int unsigned WW = 11
) (
  input logic          clk,
  input logic          arst_n,
  input logic          tick_i,
  input logic [1:0]    wd_sel_i,
  input logic          supply_ok,
  input logic          rst_active,
  input logic [HW-1:0] hold_cnt,
  input logic          cs_fall,
  input logic          wd_fire,
  input logic [WW-1:0] wd_cnt
);

  AST_BAD_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_ok |=> (hold_cnt == '0) && rst_active);  // R3

  AST_RELEASE_ON_FULL_COUNT: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_active) |-> $past(tick_i) && ($past(hold_cnt) == HW'(HOLD_TICKS - 1)));  // R2

  AST_WD_FIRE_RESETS: assert property (@(posedge clk) disable iff (!arst_n)
    wd_fire |=> rst_active);  // R5

  AST_WD_ZERO_IN_RESET: assert property (@(posedge clk) disable iff (!arst_n)
    rst_active |=> (wd_cnt == '0));  // R7

  AST_WD_KICK_CLEARS: assert property (@(posedge clk) disable iff (!arst_n)
    cs_fall |=> (wd_cnt == '0));  // R6

  AST_WD_OFF_SILENT: assert property (@(posedge clk) disable iff (!arst_n)
    wd_fire |-> (wd_sel_i != 2'b11));  // R9

endmodule

bind supply_reset_seq supply_reset_seq_chk #(
  .HOLD_TICKS(HOLD_TICKS),
  .HW        (HW),
  .WW        (WW)
) u_chk (
  .clk       (clk),
  .arst_n    (arst_n),
  .tick_i    (tick_i),
  .wd_sel_i  (wd_sel_i),
  .supply_ok (supply_ok),
  .rst_active(rst_active),
  .hold_cnt  (hold_cnt),
  .cs_fall   (cs_fall),
  .wd_fire   (wd_fire),
  .wd_cnt    (wd_cnt)
);

// File: tb/supply_reset_seq_bench.sv
`timescale 1ns/1ps
module supply_reset_seq_bench;

  localparam int HOLD = 200;
  localparam int WD_L = 1400;
  localparam int WD_M = 600;
  localparam int WD_S = 200;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       tick;
  logic       trip;
  logic       valid;
  logic       cs_n;
  logic [1:0] wd_sel;
  logic       rst_lo;
  logic       rst_hi;

  int tests  = 0;
  int failed = 0;

  always #10 clk = ~clk;  // 50 MHz

  supply_reset_seq #(.ACTIVE_LOW(1'b1)) u_supply_reset_seq (
    .clk(clk), .arst_n(arst_n), .tick_i(tick), .above_trip_i(trip),
    .supply_valid_i(valid), .cs_n_i(cs_n), .wd_sel_i(wd_sel), .rst_o(rst_lo)
  );

  supply_reset_seq #(.ACTIVE_LOW(1'b0)) u_supply_reset_seq_hi (
    .clk(clk), .arst_n(arst_n), .tick_i(tick), .above_trip_i(trip),
    .supply_valid_i(valid), .cs_n_i(cs_n), .wd_sel_i(wd_sel), .rst_o(rst_hi)
  );

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    failed++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  // exp_active: 1 when reset should be active. Both polarities checked (R8).
  task automatic expect_rst(input bit exp_active, input string what);
    tests++;
    if (rst_lo !== !exp_active || rst_hi !== exp_active) begin
      failed++;
      $display("FAIL %s: actual lo/hi=%b%b expected lo/hi=%b%b",
               what, rst_lo, rst_hi, !exp_active, exp_active);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_powerup();
    @(negedge clk);
    trip = 1'b1; valid = 1'b0;
    repeat (3) @(negedge clk);
    expect_rst(1'b1, "R4 active during power-on reset");
    arst_n = 1'b1;
    settle();
    ticks(300);
    expect_rst(1'b1, "R4 held while supply-valid low");
    valid = 1'b1;
    settle();
    ticks(HOLD - 1);
    expect_rst(1'b1, "R2 still active one tick early");
    ticks(1);
    expect_rst(1'b0, "R2 released on last tick");
    tests++;
    if (rst_lo !== 1'b1 || rst_hi !== 1'b0) begin
      failed++;
      $display("FAIL R8 idle polarity: actual lo/hi=%b%b expected lo/hi=10", rst_lo, rst_hi);
    end
  endtask

  task automatic t_trip_low();
    @(negedge clk) trip = 1'b0;
    @(negedge clk);
    expect_rst(1'b0, "R1 not yet through first sync stage");
    @(negedge clk);
    expect_rst(1'b1, "R1 asserted after two edges");
    ticks(400);
    expect_rst(1'b1, "R1 held while trip low");
    trip = 1'b1;
    settle();
    ticks(HOLD);
    expect_rst(1'b0, "R2 release after trip recovery");
  endtask

  task automatic t_dip();
    @(negedge clk) trip = 1'b0;
    settle();
    trip = 1'b1;
    settle();
    ticks(150);
    expect_rst(1'b1, "R3 mid-window");
    trip = 1'b0;
    settle();
    trip = 1'b1;
    settle();
    ticks(HOLD - 1);
    expect_rst(1'b1, "R3 count restarted after dip");
    ticks(1);
    expect_rst(1'b0, "R3 release after full recount");
  endtask

  task automatic t_valid_drop();
    @(negedge clk) valid = 1'b0;
    repeat (2) @(negedge clk);
    expect_rst(1'b1, "R4 supply-valid drop");
    valid = 1'b1;
    settle();
    ticks(HOLD);
    expect_rst(1'b0, "R4 recovery after valid returns");
  endtask

  task automatic t_wd_static(input logic [1:0] code, input int lim);
    @(negedge clk) wd_sel = code;
    ticks(lim - 1);
    expect_rst(1'b0, $sformatf("R5 code %b one tick before expiry", code));
    ticks(1);
    expect_rst(1'b1, $sformatf("R5 code %b expiry", code));
    ticks(HOLD - 1);
    expect_rst(1'b1, "R7 watchdog reset still held");
    ticks(1);
    expect_rst(1'b0, "R7 watchdog reset length");
    ticks(lim - 1);
    expect_rst(1'b0, "R7 full period needed after release");
    ticks(1);
    expect_rst(1'b1, "R7 second expiry");
    wd_sel = 2'b11;
    ticks(HOLD);
    expect_rst(1'b0, "R9 recover with watchdog off");
  endtask

  task automatic t_kick();
    @(negedge clk) wd_sel = 2'b10;
    ticks(150);
    cs_n = 1'b0;
    settle();
    ticks(WD_S - 1);
    expect_rst(1'b0, "R6 falling edge restarted count");
    ticks(1);
    expect_rst(1'b1, "R6 expiry after restart with cs low");
    ticks(HOLD);
    expect_rst(1'b0, "R7 release after kicked expiry");
    ticks(100);
    cs_n = 1'b1;
    settle();
    ticks(WD_S - 101);
    expect_rst(1'b0, "R6 rising edge before expiry");
    ticks(1);
    expect_rst(1'b1, "R6 rising edge did not restart");
    wd_sel = 2'b11;
    ticks(HOLD);
    expect_rst(1'b0, "R6 recovery");
  endtask

  task automatic t_wd_off();
    @(negedge clk) wd_sel = 2'b11;
    ticks(2000);
    expect_rst(1'b0, "R9 disabled watchdog never fires");
  endtask

  initial begin
    arst_n = 1'b0; tick = 1'b0; trip = 1'b0; valid = 1'b0;
    cs_n = 1'b1; wd_sel = 2'b11;
    t_powerup();
    t_trip_low();
    t_dip();
    t_valid_drop();
    t_wd_static(2'b10, WD_S);
    t_wd_static(2'b01, WD_M);
    t_wd_static(2'b00, WD_L);
    t_kick();
    t_wd_off();
    finish_run();
  end

endmodule